// File: doc/BRIEF.md
# Dual-slope PWM timer

A 16-bit timer that sweeps a counter up from zero to a programmable ceiling and then back down to zero, over and over. Two compare channels turn this triangle into symmetric, centre-aligned PWM waveforms. Because both edges of each pulse move together as the compare value changes, the pulse centre stays fixed in the period. A selectable clock divider sets the counting rate. A flag, with an optional interrupt, marks every return of the counter to zero.

Software programs the block through a small synchronous register port. It sets the ceiling, the two compare levels, the divider code and the enables. It can also load the counter directly, restart the divider and clear the flag. New ceiling and compare values are held in shadow registers and take effect only at the start of a fresh period. A read address returns any register. It also returns the elapsed position within the current period, which grows monotonically from 0 to twice the ceiling even while the counter falls.

Top module: `dualslope_pwm_timer`

## Requirements
- R1: While running, the count readback (address 4) steps 0,1,…,T,T-1,…,1,0,1,… one step per divider tick, where T is the active ceiling (T ≥ 1). A period is therefore 2·T ticks.
- R2: The control register (address 0) holds the divider code in bits [2:0], enable A in bit 3, enable B in bit 4 and the interrupt enable in bit 5. Code 1 ticks every clock, 2 every 8, 3 every 64, 4 every 256 and 5 every 1024. Codes 0, 6 and 7 stop the counter at its present value, and a later running code continues from that value.
- R3: Status bit 0 (address 5) becomes 1 on the tick that brings the counter to 0, and never at the ceiling. Writing address 5 with data bit 0 set clears it, and a new zero arrival in the same cycle wins over the clear.
- R4: The interrupt output equals the status flag when control bit 5 is 1 and is 0 otherwise. Clearing bit 5 leaves the counter running.
- R5: Each PWM output (A, B) is high while counting up with count < C and while counting down with count ≤ C, where C is that channel's active compare value. It is 0 whenever its enable bit is 0, and a compare value of 0 holds it low.
- R6: Writes to the ceiling (address 1) and to the compare registers (A at 2, B at 3) land in shadow registers that read back at once. They become active only on the tick that returns the counter to 0, or on any clock edge while the counter is stopped.
- R7: A write to address 4 loads the counter with the data and sets the direction to up. It takes priority over a tick in the same cycle, and that cycle raises no zero event.
- R8: A write to address 7 clears the divider's internal phase. With code 2 selected right after, the first tick arrives exactly 8 clocks after the code becomes active. Address 7 reads 0.
- R9: Address 6 returns the elapsed position: the count while counting up, and 2·T minus the count while counting down.
- R10: After reset every readable register, the count, the flag and all outputs are 0.
- R11: With a ceiling of 1 the count alternates 0,1 and reaches 0 every second tick. With a ceiling of 0 the count stays 0 and every tick is a zero event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 17 | Read data for rd_addr (combinational) |
| pwm_a | output | 1 | PWM waveform of channel A |
| pwm_b | output | 1 | PWM waveform of channel B |
| irq | output | 1 | Interrupt request (flag gated by enable) |

## Verification
The bench targets the turn-around at the ceiling and the arrival at zero. A design that raised its event at the ceiling, or repeated the ceiling or zero step, would shift the flag and the elapsed readback by whole ticks. The bench moves the ceiling and compare values in the middle of a period, which catches a design that applies them at once and produces one truncated or stretched period. It also checks the divider restart, the freeze and resume on stop codes, and the ceilings of 0 and 1. A wrong divider phase shows up as a first tick arriving early. A missed stop code lets the count drift. A ceiling of 0 or 1 that is decoded badly makes the counter run past its ceiling or lose zero events.

// File: rtl/dspt_pkg.sv
package dspt_pkg;

  // register map
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_TOP  = 3'd1;
  localparam logic [2:0] A_CMPA = 3'd2;
  localparam logic [2:0] A_CMPB = 3'd3;
  localparam logic [2:0] A_CNT  = 3'd4;
  localparam logic [2:0] A_STAT = 3'd5;
  localparam logic [2:0] A_ELAP = 3'd6;
  localparam logic [2:0] A_PRST = 3'd7;

  localparam int CTRL_W = 6;

  typedef struct packed {
    logic       irq_en;
    logic       en_b;
    logic       en_a;
    logic [2:0] sel;
  } ctrl_t;

  // divider codes 1..5 run the counter, all others hold it
  function automatic logic sel_runs(logic [2:0] s);
    return (s >= 3'd1) && (s <= 3'd5);
  endfunction

  // log2 of the clock divide ratio for a divider code
  function automatic logic [3:0] div_shift(logic [2:0] s);
    case (s)
      3'd2:    return 4'd3;
      3'd3:    return 4'd6;
      3'd4:    return 4'd8;
      3'd5:    return 4'd10;
      default: return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/dspt_prescaler.sv
module dspt_prescaler
  import dspt_pkg::*;
#(
  parameter int PRE_W = 10
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] sel,
  input  logic       restart,
  output logic       tick
);

  logic [PRE_W-1:0] phase_q;
  logic             running;

  // last phase value of a divide window
  function automatic logic [PRE_W-1:0] last_phase(logic [2:0] s);
    return PRE_W'((32'd1 << div_shift(s)) - 32'd1);
  endfunction

  assign running = sel_runs(sel);
  // ">=" lets a switch to a shorter ratio end the window at once
  assign tick    = running && (phase_q >= last_phase(sel));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= '0;
    end else if (restart) begin
      phase_q <= '0;
    end else if (running) begin
      phase_q <= tick ? '0 : phase_q + 1'b1;
    end
  end

endmodule

// File: rtl/dspt_updown.sv
module dspt_updown #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] top,
  output logic [W-1:0] cnt,
  output logic         down,
  output logic         bottom_evt
);

  localparam int NW = W + 2;

  logic [W-1:0]  cnt_q;
  logic          down_q;
  logic [NW-1:0] nxt;

  // next state packed as {reaches_zero, down, count}
  function automatic logic [NW-1:0] advance(logic [W-1:0] c, logic d, logic [W-1:0] t);
    if (!d && (c < t)) begin
      return {1'b0, 1'b0, c + 1'b1};
    end else if (c <= W'(1)) begin
      return {1'b1, 1'b0, {W{1'b0}}};
    end else begin
      return {1'b0, 1'b1, c - 1'b1};
    end
  endfunction

  assign nxt        = advance(cnt_q, down_q, top);
  assign bottom_evt = tick && !load && nxt[W+1];
  assign cnt        = cnt_q;
  assign down       = down_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      down_q <= 1'b0;
    end else if (load) begin
      cnt_q  <= load_val;
      down_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= nxt[W-1:0];
      down_q <= nxt[W];
    end
  end

endmodule

// File: rtl/dspt_cmp.sv
module dspt_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] cnt,
  input  logic         down,
  input  logic [W-1:0] cmp,
  input  logic         en,
  output logic         pwm
);

  // clears on the match going up, sets on the match going down
  function automatic logic level(logic [W-1:0] c, logic d, logic [W-1:0] m);
    if (m == '0) return 1'b0;
    return d ? (c <= m) : (c < m);
  endfunction

  assign pwm = en && level(cnt, down, cmp);

endmodule

// File: rtl/dualslope_pwm_timer.sv
module dualslope_pwm_timer
  import dspt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PRE_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W:0]   rd_data,
  output logic             pwm_a,
  output logic             pwm_b,
  output logic             irq
);

  localparam int NCH = 2;
  localparam int EW  = CNT_W + 1;

  ctrl_t                       ctrl_q;
  logic [CNT_W-1:0]            top_buf, top_act;
  logic [NCH-1:0][CNT_W-1:0]   cmp_buf, cmp_act;
  logic                        flag_q;

  // named internal events
  logic             stopped;
  logic             reload;
  logic             cnt_wr;
  logic             flag_clr;
  logic             pre_restart;
  logic             tick;
  logic             bottom_evt;
  logic [CNT_W-1:0] cnt_q;
  logic             dir_down;
  logic [NCH-1:0]   ch_en;
  logic [NCH-1:0]   pwm_vec;

  function automatic logic [EW-1:0] elapsed_of(logic [CNT_W-1:0] c, logic d,
                                               logic [CNT_W-1:0] t);
    return d ? ({t, 1'b0} - {1'b0, c}) : {1'b0, c};
  endfunction

  assign stopped     = !sel_runs(ctrl_q.sel);
  assign reload      = bottom_evt || stopped;
  assign cnt_wr      = wr_en && (wr_addr == A_CNT);
  assign flag_clr    = wr_en && (wr_addr == A_STAT) && wr_data[0];
  assign pre_restart = wr_en && (wr_addr == A_PRST);
  assign ch_en       = {ctrl_q.en_b, ctrl_q.en_a};

  dspt_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (ctrl_q.sel),
    .restart (pre_restart),
    .tick    (tick)
  );

  dspt_updown #(.W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .load       (cnt_wr),
    .load_val   (wr_data),
    .top        (top_act),
    .cnt        (cnt_q),
    .down       (dir_down),
    .bottom_evt (bottom_evt)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    dspt_cmp #(.W(CNT_W)) u_cmp (
      .cnt  (cnt_q),
      .down (dir_down),
      .cmp  (cmp_act[ch]),
      .en   (ch_en[ch]),
      .pwm  (pwm_vec[ch])
    );

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cmp_buf[ch] <= '0;
        cmp_act[ch] <= '0;
      end else begin
        if (reload) cmp_act[ch] <= cmp_buf[ch];
        if (wr_en && (wr_addr == 3'(A_CMPA + ch))) cmp_buf[ch] <= wr_data;
      end
    end
  end

  assign pwm_a = pwm_vec[0];
  assign pwm_b = pwm_vec[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      top_buf <= '0;
      top_act <= '0;
    end else begin
      if (reload) top_act <= top_buf;
      if (wr_en && (wr_addr == A_TOP)) top_buf <= wr_data;
      if (wr_en && (wr_addr == A_CTRL)) ctrl_q <= ctrl_t'(wr_data[CTRL_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (bottom_evt) begin
      flag_q <= 1'b1;
    end else if (flag_clr) begin
      flag_q <= 1'b0;
    end
  end

  assign irq = flag_q && ctrl_q.irq_en;

  always_comb begin
    case (rd_addr)
      A_CTRL:  rd_data = {{(EW-CTRL_W){1'b0}}, ctrl_q};
      A_TOP:   rd_data = {1'b0, top_buf};
      A_CMPA:  rd_data = {1'b0, cmp_buf[0]};
      A_CMPB:  rd_data = {1'b0, cmp_buf[1]};
      A_CNT:   rd_data = {1'b0, cnt_q};
      A_STAT:  rd_data = {{(EW-1){1'b0}}, flag_q};
      A_ELAP:  rd_data = elapsed_of(cnt_q, dir_down, top_act);
      default: rd_data = '0;
    endcase
  end

endmodule

// File: rtl/dspt_chk.sv
module dspt_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         bottom_evt,
  input logic         flag_q,
  input logic         flag_clr,
  input logic         irq,
  input logic         stopped,
  input logic         cnt_wr,
  input logic [W-1:0] cnt_q,
  input logic         dir_down,
  input logic [W-1:0] top_act,
  input logic [W-1:0] cmp_a,
  input logic         pwm_a
);

  // R1: a falling count never sits at zero
  p_down_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dir_down |-> (cnt_q != '0));

  // R2: a stop code freezes the count
  p_stop_freeze_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (stopped && !cnt_wr) |=> $stable(cnt_q));

  // R3: zero event sets the flag and leaves the count at zero
  p_bottom_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bottom_evt |=> (flag_q && (cnt_q == '0)));

  // R3: write-one clear without a competing zero event
  p_flag_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !bottom_evt) |=> !flag_q);

  // R4: interrupt only with the flag raised
  p_irq_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flag_q);

  // R5: zero compare holds channel A low
  p_zero_cmp_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_a == '0) |-> !pwm_a);

  // R6: active ceiling only changes at zero or while stopped
  p_top_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!stopped && !bottom_evt) |=> $stable(top_act));

  // R7: a counter load restarts the up slope
  p_cnt_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> !dir_down);

endmodule

bind dualslope_pwm_timer dspt_chk #(.W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bottom_evt (bottom_evt),
  .flag_q     (flag_q),
  .flag_clr   (flag_clr),
  .irq        (irq),
  .stopped    (stopped),
  .cnt_wr     (cnt_wr),
  .cnt_q      (cnt_q),
  .dir_down   (dir_down),
  .top_act    (top_act),
  .cmp_a      (cmp_act[0]),
  .pwm_a      (pwm_a)
);

// File: tb/sim_dualslope_pwm_timer.sv
module sim_dualslope_pwm_timer;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   wr_addr = '0;
  logic [2:0]   rd_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic [W:0]   rd_data;
  logic         pwm_a, pwm_b, irq;

  always #10 clk = ~clk;

  dualslope_pwm_timer u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .pwm_a(pwm_a), .pwm_b(pwm_b), .irq(irq)
  );

  int    total = 0;
  int    bad = 0;
  bit    finished = 1'b0;
  string cnt_tag = "R1";

  // reference state: phase m_p runs 0..2T-1 across one period
  int       m_p, m_T, m_tb, m_ca, m_cb, m_cab, m_cbb, m_pre;
  int       m_sel;
  bit       m_ena, m_enb, m_ie, m_flag;

  function automatic int shift_of(int s);
    case (s)
      2: return 3;
      3: return 6;
      4: return 8;
      5: return 10;
      default: return 0;
    endcase
  endfunction

  function automatic bit runs(int s);
    return (s >= 1) && (s <= 5);
  endfunction

  function automatic int exp_cnt();
    return (m_p <= m_T) ? m_p : 2 * m_T - m_p;
  endfunction

  // high for the first C steps of the period and the last C steps of the fall
  function automatic bit exp_level(int c);
    return (m_p < c) || ((m_p > m_T) && (m_p + c >= 2 * m_T));
  endfunction

  function automatic int exp_rd(int a);
    case (a)
      0: return (int'(m_ie) << 5) | (int'(m_enb) << 4) | (int'(m_ena) << 3) | m_sel;
      1: return m_tb;
      2: return m_cab;
      3: return m_cbb;
      4: return exp_cnt();
      5: return int'(m_flag);
      6: return m_p;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int a);
    case (a)
      0: return "R2";
      1, 2, 3: return "R6";
      4: return cnt_tag;
      5: return "R3";
      6: return "R9";
      default: return "R8";
    endcase
  endfunction

  function automatic int ctrlv(bit ie, bit eb, bit ea, int s);
    return (int'(ie) << 5) | (int'(eb) << 4) | (int'(ea) << 3) | s;
  endfunction

  always @(posedge clk) begin : model
    bit run, tk, bot, rel;
    int np;
    if (!rst_n) begin
      m_p = 0; m_T = 0; m_tb = 0; m_ca = 0; m_cb = 0; m_cab = 0; m_cbb = 0;
      m_pre = 0; m_sel = 0; m_ena = 0; m_enb = 0; m_ie = 0; m_flag = 0;
    end else begin
      run = runs(m_sel);
      tk  = run && (m_pre >= (1 << shift_of(m_sel)) - 1);
      bot = 1'b0;
      np  = m_p;
      if (wr_en && wr_addr == 3'd4) begin
        np = int'(wr_data);
      end else if (tk) begin
        if (m_T == 0) begin
          np = 0; bot = 1'b1;
        end else begin
          np = (m_p + 1) % (2 * m_T);
          bot = (np == 0);
        end
      end
      rel = bot || !run;
      if (rel) begin
        m_T = m_tb; m_ca = m_cab; m_cb = m_cbb;
      end
      m_p = np;
      if (bot) m_flag = 1'b1;
      else if (wr_en && wr_addr == 3'd5 && wr_data[0]) m_flag = 1'b0;
      if (wr_en && wr_addr == 3'd7) m_pre = 0;
      else if (run) m_pre = tk ? 0 : m_pre + 1;
      if (wr_en) begin
        case (wr_addr)
          3'd0: begin
            m_sel = int'(wr_data[2:0]); m_ena = wr_data[3];
            m_enb = wr_data[4]; m_ie = wr_data[5];
          end
          3'd1: m_tb  = int'(wr_data);
          3'd2: m_cab = int'(wr_data);
          3'd3: m_cbb = int'(wr_data);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got=%0d exp=%0d (t=%0t)", tag, got, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk(tag_of(int'(rd_addr)), int'(rd_data), exp_rd(int'(rd_addr)));
    chk("R5", int'(pwm_a), int'(m_ena && exp_level(m_ca)));
    chk("R5", int'(pwm_b), int'(m_enb && exp_level(m_cb)));
    chk("R4", int'(irq), int'(m_flag && m_ie));
  endtask

  task automatic idle(int n);
    repeat (n) step();
  endtask

  task automatic wr(int a, int d);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = W'(d);
    step();
    wr_en = 1'b0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : stim
    int v, n, r;
    v = $urandom(32'd5150);
    idle(3);
    rst_n = 1'b1;
    // R10: everything idle after reset
    for (int a = 0; a < 7; a++) begin
      rd_addr = 3'(a);
      step();
      chk("R10", int'(rd_data), 0);
    end
    chk("R10", int'(pwm_a | pwm_b | irq), 0);

    // setup while stopped, then run: basic triangle
    wr(1, 6); wr(2, 3); wr(3, 6);
    wr(0, ctrlv(1, 1, 1, 0));
    idle(2);
    rd_addr = 3'd4;
    wr(0, ctrlv(1, 1, 1, 1));
    idle(30);
    rd_addr = 3'd6;
    idle(14);

    // R2: freeze and resume
    cnt_tag = "R2";
    rd_addr = 3'd4;
    wr(0, ctrlv(1, 1, 1, 0));
    v = int'(rd_data);
    idle(6);
    chk("R2", int'(rd_data), v);
    wr(0, ctrlv(1, 1, 1, 6));
    idle(4);
    chk("R2", int'(rd_data), v);
    wr(0, ctrlv(1, 1, 1, 1));
    idle(5);

    // R6: shadow registers changed mid period
    cnt_tag = "R6";
    wr(1, 3); idle(30);
    wr(2, 5); idle(20);
    wr(3, 0); idle(20);

    // R7: counter load while falling and rising
    cnt_tag = "R7";
    wr(4, 2); idle(10);
    wr(4, 0); idle(8);

    // R8: divider restart gives a full first window
    cnt_tag = "R8";
    wr(0, ctrlv(1, 1, 1, 2)); idle(3);
    wr(0, ctrlv(1, 1, 1, 0));
    wr(4, 0); wr(7, 0);
    rd_addr = 3'd4;
    wr(0, ctrlv(1, 1, 1, 2));
    n = 0;
    do begin
      step(); n++;
    end while (rd_data == 0 && n < 40);
    chk("R8", n, 8);
    idle(40);

    // R2: slower divide codes
    cnt_tag = "R2";
    wr(0, ctrlv(1, 1, 1, 3)); idle(200);
    wr(0, ctrlv(1, 1, 1, 4)); idle(600);
    wr(0, ctrlv(1, 1, 1, 5)); idle(2100);

    // R11: ceilings of 1 and 0
    cnt_tag = "R11";
    wr(0, ctrlv(1, 1, 1, 0)); wr(4, 0); wr(1, 1); idle(1);
    wr(0, ctrlv(1, 1, 1, 1)); idle(6);
    rd_addr = 3'd5; idle(4);
    rd_addr = 3'd4;
    wr(0, ctrlv(1, 1, 1, 0)); wr(4, 0); wr(1, 0); idle(2);
    wr(0, ctrlv(1, 1, 1, 1)); idle(10);

    // R3 / R4: flag clear and interrupt gating
    cnt_tag = "R1";
    wr(0, ctrlv(1, 1, 1, 0)); wr(4, 0); wr(1, 10); idle(1);
    wr(0, ctrlv(1, 1, 1, 1));
    rd_addr = 3'd5;
    idle(25);
    wr(5, 1); idle(3);
    wr(5, 0); idle(3);
    wr(5, 1);
    wr(0, ctrlv(0, 1, 1, 1)); idle(25);
    rd_addr = 3'd4;
    idle(3);
    wr(0, ctrlv(1, 1, 1, 1)); idle(5);

    // constrained random traffic
    wr(0, ctrlv(1, 1, 1, 0)); wr(4, 0); wr(1, 20); idle(1);
    wr(0, ctrlv(1, 1, 1, 1));
    for (int i = 0; i < 4000; i++) begin
      rd_addr = 3'($urandom % 8);
      r = int'($urandom % 100);
      if (r < 4)       wr(1, 1 + int'($urandom % 40));
      else if (r < 8)  wr(2, int'($urandom % 46));
      else if (r < 12) wr(3, int'($urandom % 46));
      else if (r < 15) wr(0, ctrlv(1'($urandom), 1'($urandom), 1'($urandom),
                                   (($urandom % 4) == 0) ? 2 + int'($urandom % 2) : 1));
      else if (r < 17) wr(4, int'($urandom % (m_T + 1)));
      else if (r < 20) wr(5, int'($urandom % 2));
      else if (r < 22) wr(7, 0);
      else             step();
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule